// File: doc/BRIEF.md
# Serial Register Port with Streaming Access

This block is a serial slave that gives a host read and write access to a file of byte-wide registers (128 locations by default). The host holds chip select low and sends a 16-bit instruction, most significant bit first. The first bit selects read (1) or write (0), and the remaining 15 bits carry the start address. Any number of data bytes then follow. After every byte the address advances by one, so a single frame can fill or dump a run of consecutive registers.

Serial clock, chip select and input data are brought into the system clock domain through two-stage synchronizers. The system clock must run at least four times faster than the serial clock. Input data is taken on the serial clock rising edge, and read data is launched on the falling edge. The last written byte reaches the register file when chip select returns high.

Two locations have special meaning. The configuration register at address 0x000 picks where read data leaves the block: the separate output line in 4-wire mode, or the shared data line, under output-enable control, in 3-wire mode. The control register at address 0x02A emits one-cycle pulses to two external sequencers.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset every register reads 0, `seq_strb` is 0, and neither `sdio_oe` nor `sdo` is asserted.
- R2: While `cs_n` is high, toggling `sclk` and `sdio_i` has no effect: no register changes, no strobe fires, and neither data output is driven.
- R3: A frame starts with a 16-bit instruction, MSB first: bit 15 = 1 selects read, bits 14:0 hold the start address. Input bits are taken on the `sclk` rising edge, and read bits are launched on the falling edge, MSB first.
- R4: Every complete data byte of a write frame is stored. The last byte is committed when `cs_n` rises. A byte left incomplete when `cs_n` rises is discarded.
- R5: In a write frame the address advances by one after each data byte, so consecutive registers are written without new instructions.
- R6: In a read frame the address advances by one after each data byte, returning consecutive registers until `cs_n` rises.
- R7: Writes to addresses at or above the register count are ignored, and reads from them return 0.
- R8: When configuration bits [4:3] of address 0x000 are not both 1 (reset default 00), read data appears on `sdio_o` with `sdio_oe` high during the data bits of a read frame only, and `sdo` stays 0.
- R9: When configuration bits [4:3] of address 0x000 are both 1, read data appears on `sdo` and `sdio_oe` stays low.
- R10: Writing address 0x02A makes each bit written as 1 among bits 3 (multiplier reset), 2 (multiplier advance), 1 (receiver reset) and 0 (receiver advance) pulse the same bit of `seq_strb` high for exactly one clock. Reading 0x02A returns 0, reserved bits [7:4] included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data input (pad input of the shared line) |
| sdio_o | output | 1 | Read data toward the shared line in 3-wire mode |
| sdio_oe | output | 1 | Output enable of the shared line |
| sdo | output | 1 | Read data on the separate line in 4-wire mode |
| seq_strb | output | 4 | Sequencer pulses: [3] mult reset, [2] mult advance, [1] rx reset, [0] rx advance |

## Verification
Each serial edge reaches the block's logic two system clocks after it occurs. A read bit is registered one clock later, three clocks after the falling edge. The bench therefore holds each `sclk` phase for four clocks and samples the data lines and `sdio_oe` on the last clock of the low phase, just before it raises `sclk`. The final write commit and any sequencer pulse appear three to four clocks after `cs_n` rises. The bench waits ten clocks after releasing chip select before it reads back or compares pulse counts. It counts strobe pulses and high cycles on every clock, so a pulse that lasts longer than one clock shows up as a mismatch between the two counts.

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
  parameter int ADDR_W = 7,
  parameter int INSTR_W = 16,
  parameter int CFG_ADDR = 'h000,
  parameter int STRB_ADDR = 'h02A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       sdio_i,
  output logic       sdio_o,
  output logic       sdio_oe,
  output logic       sdo,
  output logic [3:0] seq_strb
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int AW = INSTR_W - 1;
  localparam logic [4:0] LAST_INSTR = 5'(INSTR_W - 1);
  localparam logic [4:0] FIRST_DATA = 5'(INSTR_W);
  localparam logic [4:0] LAST_DATA = 5'(INSTR_W + 7);

  logic [2:0] sck_q, cs_q;
  logic [1:0] sdi_q;
  logic [4:0] cnt;
  logic [AW-1:0] shreg, addr, pend_addr;
  logic [7:0] pend_data;
  logic rd, pend_v, out_bit;
  logic [7:0] mem [DEPTH];

  wire sel       = ~cs_q[1];
  wire cs_rise   = cs_q[1] & ~cs_q[2];
  wire sck_rise  = sck_q[1] & ~sck_q[2];
  wire sck_fall  = ~sck_q[1] & sck_q[2];
  wire sdi       = sdi_q[1];
  wire in_data   = cnt >= FIRST_DATA;
  wire byte_done = sel & sck_rise & (cnt == LAST_DATA);
  wire commit    = pend_v & (cs_rise | (byte_done & ~rd));
  wire four_wire = mem[CFG_ADDR][4:3] == 2'b11;
  wire rd_ok     = (addr < AW'(DEPTH)) && (addr != AW'(STRB_ADDR));
  wire wr_ok     = (pend_addr < AW'(DEPTH)) && (pend_addr != AW'(STRB_ADDR));
  wire [7:0] rd_data = rd_ok ? mem[addr[ADDR_W-1:0]] : 8'h00;

  assign sdio_oe = sel & rd & in_data & ~four_wire;
  assign sdio_o  = sdio_oe & out_bit;
  assign sdo     = sel & rd & in_data & four_wire & out_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      sdi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      cs_q  <= {cs_q[1:0], cs_n};
      sdi_q <= {sdi_q[0], sdio_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; rd <= 1'b0; addr <= '0; shreg <= '0;
      pend_v <= 1'b0; pend_addr <= '0; pend_data <= '0; out_bit <= 1'b0;
    end else begin
      if (commit) pend_v <= 1'b0;
      if (!sel) begin
        cnt <= '0;
        rd  <= 1'b0;
      end else begin
        if (sck_rise) begin
          shreg <= {shreg[AW-2:0], sdi};
          if (cnt == LAST_INSTR) begin
            rd   <= shreg[AW-1];
            addr <= {shreg[AW-2:0], sdi};
            cnt  <= FIRST_DATA;
          end else if (cnt == LAST_DATA) begin
            cnt  <= FIRST_DATA;
            addr <= addr + 1'b1;
            if (!rd) begin
              pend_v    <= 1'b1;
              pend_addr <= addr;
              pend_data <= {shreg[6:0], sdi};
            end
          end else
            cnt <= cnt + 1'b1;
        end
        if (sck_fall && rd && in_data) out_bit <= rd_data[~cnt[2:0]];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit && wr_ok)
      mem[pend_addr[ADDR_W-1:0]] <= pend_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seq_strb <= '0;
    else seq_strb <= (commit && pend_addr == AW'(STRB_ADDR)) ? pend_data[3:0] : 4'h0;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) |-> !sdio_oe && !sdo); // R2
  AST_CS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !pend_v); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> addr == $past(addr) + 1'b1); // R5
  AST_FOUR_WIRE_SHARED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    four_wire |-> !sdio_oe); // R9
  AST_STRB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_strb != 4'h0 |=> seq_strb == 4'h0); // R10
endmodule

// File: tb/spi_regfile_slave_tb.sv
module spi_regfile_slave_tb;
  localparam int HALF = 4;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo;
  logic [3:0] seq_strb;
  int n_chk = 0, n_fail = 0;
  bit four = 1'b0, done = 1'b0;
  int oe_bad;
  logic [7:0] wbuf [0:255];
  logic [7:0] rbuf [0:255];
  logic [7:0] model [0:127];
  int pulses [4], highs [4], exp_p [4];
  logic [3:0] strb_q = 4'h0;

  spi_regfile_slave u_dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .seq_strb(seq_strb));

  always #10 clk = ~clk;

  initial for (int i = 0; i < 4; i++) begin pulses[i] = 0; highs[i] = 0; exp_p[i] = 0; end

  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (seq_strb[i]) highs[i]++;
      if (seq_strb[i] && !strb_q[i]) pulses[i]++;
    end
    strb_q = seq_strb;
  end

  function automatic logic [7:0] pat(input int a);
    return (a == 0) ? 8'h05 : 8'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input bit rd, input logic [14:0] a, input int nbytes, input int extra);
    logic [15:0] ins;
    ins = {rd, a};
    oe_bad = 0;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < 16 + 8 * nbytes + extra; k++) begin
      int bi, bp;
      bi = (k - 16) / 8; bp = 7 - ((k - 16) % 8);
      if (k < 16) sdio_i = ins[15 - k];
      else sdio_i = rd ? 1'b0 : wbuf[bi][bp];
      repeat (HALF) @(negedge clk);
      if (k >= 16 && rd) begin
        rbuf[bi][bp] = four ? sdo : sdio_o;
        if (sdio_oe !== !four) oe_bad++;
        if (!four && sdo !== 1'b0) oe_bad++;
      end else if (sdio_oe !== 1'b0 || sdo !== 1'b0) oe_bad++;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic strb_chk(input string req);
    bit ok;
    ok = 1'b1;
    for (int i = 0; i < 4; i++) if (pulses[i] != exp_p[i] || highs[i] != exp_p[i]) ok = 1'b0;
    chk(ok, req, pulses[3] * 4096 + pulses[2] * 256 + pulses[1] * 16 + pulses[0],
        exp_p[3] * 4096 + exp_p[2] * 256 + exp_p[1] * 16 + exp_p[0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdio_oe === 1'b0 && sdo === 1'b0 && seq_strb === 4'h0, "R1 idle outputs",
        {sdio_oe, sdo, seq_strb}, 0);

    // R1 R6 R8: whole file reads zero in 3-wire mode
    frame(1'b1, 15'h0000, 128, 0);
    for (int a = 0; a < 128; a++) chk(rbuf[a] === 8'h00, "R1 R6 reset value", rbuf[a], 0);
    chk(oe_bad == 0, "R8 3-wire drive window", oe_bad, 0);

    // R5: block write over the whole file
    for (int a = 0; a < 128; a++) begin wbuf[a] = pat(a); model[a] = pat(a); end
    model[42] = 8'h00;
    for (int i = 0; i < 4; i++) if (pat(42)[i]) exp_p[i]++;
    frame(1'b0, 15'h0000, 128, 0);
    strb_chk("R10 pulses from block write");
    frame(1'b1, 15'h0000, 128, 0);
    for (int a = 0; a < 128; a++) chk(rbuf[a] === model[a], "R5 R6 block readback", rbuf[a], model[a]);

    // R7: writes across the top of the file
    wbuf[0] = 8'hC3; wbuf[1] = 8'h5A; wbuf[2] = 8'hFF;
    frame(1'b0, 15'h007E, 3, 0);
    model[126] = 8'hC3; model[127] = 8'h5A;
    frame(1'b1, 15'h007E, 4, 0);
    chk(rbuf[0] === 8'hC3, "R7 below top", rbuf[0], 8'hC3);
    chk(rbuf[1] === 8'h5A, "R7 last location", rbuf[1], 8'h5A);
    chk(rbuf[2] === 8'h00 && rbuf[3] === 8'h00, "R7 beyond top", {rbuf[2], rbuf[3]}, 0);
    wbuf[0] = 8'h99;
    frame(1'b0, 15'h4005, 1, 0);
    frame(1'b1, 15'h0005, 1, 0);
    chk(rbuf[0] === model[5], "R3 R7 high address bits", rbuf[0], model[5]);

    // R4: incomplete byte discarded at chip select rise
    wbuf[0] = 8'h3C; wbuf[1] = 8'hFF;
    frame(1'b0, 15'h000A, 1, 5);
    model[10] = 8'h3C;
    frame(1'b1, 15'h000A, 2, 0);
    chk(rbuf[0] === 8'h3C, "R4 last full byte", rbuf[0], 8'h3C);
    chk(rbuf[1] === model[11], "R4 partial byte", rbuf[1], model[11]);

    // R2: activity with chip select high
    begin
      logic [23:0] junk;
      junk = {1'b0, 15'h002A, 8'hFF};
      oe_bad = 0;
      for (int k = 0; k < 24; k++) begin
        sdio_i = junk[23 - k];
        repeat (HALF) @(negedge clk);
        if (sdio_oe !== 1'b0 || sdo !== 1'b0) oe_bad++;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
      end
      repeat (10) @(negedge clk);
      chk(oe_bad == 0, "R2 outputs quiet", oe_bad, 0);
      strb_chk("R2 no strobe");
      frame(1'b1, 15'h000A, 1, 0);
      chk(rbuf[0] === model[10], "R2 register unchanged", rbuf[0], model[10]);
    end

    // R9 then R8 with bits 01
    wbuf[0] = 8'h18;
    frame(1'b0, 15'h0000, 1, 0);
    four = 1'b1; model[0] = 8'h18;
    frame(1'b1, 15'h0000, 8, 0);
    for (int a = 0; a < 8; a++) chk(rbuf[a] === model[a], "R9 4-wire data", rbuf[a], model[a]);
    chk(oe_bad == 0, "R9 shared line released", oe_bad, 0);
    wbuf[0] = 8'h08;
    frame(1'b0, 15'h0000, 1, 0);
    four = 1'b0; model[0] = 8'h08;
    frame(1'b1, 15'h0000, 2, 0);
    chk(rbuf[0] === 8'h08 && rbuf[1] === model[1], "R8 mode bits 01", rbuf[0], 8'h08);
    chk(oe_bad == 0, "R8 drive window", oe_bad, 0);

    // R10: sweep every strobe pattern
    for (int v = 0; v < 16; v++) begin
      wbuf[0] = {4'hF, 4'(v)};
      for (int i = 0; i < 4; i++) if (v[i]) exp_p[i]++;
      frame(1'b0, 15'h002A, 1, 0);
      strb_chk("R10 strobe pulses");
    end
    frame(1'b1, 15'h002A, 1, 0);
    chk(rbuf[0] === 8'h00, "R10 readback zero", rbuf[0], 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule